// File: doc/BRIEF.md
# Real-Time Clock Alarm and Interrupt Controller

This block sits beside a BCD time-of-day and calendar counter. It does not count time itself. It receives the counter's current time word and calendar word, plus single-cycle event pulses: a once-per-second tick, a time-field event, a calendar-field event and an update acknowledge.

Software programs two alarm words through a small register port. Each alarm field has its own match-enable bit inside the word. On each second tick, the block compares the enabled fields with the live counter values. A full match raises a sticky alarm status bit.

All five event sources land in a sticky status register that software clears by writing ones. An interrupt mask is raised through one register address, lowered through another, and read back through a third. The single level interrupt output is high while any unmasked status bit is set. A validity register reports, bit by bit, whether the live time, the live calendar and each stored alarm word hold legal BCD within range. An illegal alarm word disables alarm matching until it is rewritten with a legal value.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset:
  - the status and mask registers read 0 and `irq_o` is low;
  - the time alarm reads 0x0000_0000;
  - the calendar alarm reads 0x0101_0000 (month 01, date 01, no enables).
- R2: The register word address on `reg_addr_i` selects the register:
  - 0: time alarm (read/write);
  - 1: calendar alarm (read/write);
  - 2: status (read-only);
  - 3: clear command (write-only);
  - 4: mask raise (write-only);
  - 5: mask lower (write-only);
  - 6: mask (read-only);
  - 7: validity (read-only).
  Write-only addresses read 0, and writes to read-only addresses change nothing.
- R3: Time alarm word layout:
  - second in [6:0], with its enable in bit 7;
  - minute in [14:8], with its enable in bit 15;
  - hour in [21:16], with its enable in bit 23.
  Only these bits are stored, so readback is the written value ANDed with 0x00BF_FFFF.
- R4: Calendar alarm word layout:
  - month in [20:16], with its enable in bit 23;
  - date in [29:24], with its enable in bit 31.
  Readback is the written value ANDed with 0xBF9F_0000. There is no year or century comparison, so the live year and century never affect a match.
- R5: Status bit 1 (alarm) is set on the rising clock edge that samples `sec_ev_i` high while every enabled alarm field equals the same field of `time_i`/`cal_i` (same bit positions). Fields whose enable bit is clear are not compared. With no enable bit set, the alarm never fires.
- R6: Range rules for stored alarm fields: second and minute 00–59, hour 00–23, month 01–12, date 01–31. A field is illegal if either nibble exceeds 9 or the value is out of range.
  - An illegal field in the time alarm sets validity bit 2.
  - An illegal field in the calendar alarm sets validity bit 3.
  - While either bit is set, status bit 1 is never set. Rewriting a legal value restores matching.
- R7: Validity bits 0 and 1 combinationally flag an illegal live time word and live calendar word.
  - Time word fields: second, minute and hour, with the ranges of R6.
  - Calendar word fields: century [6:0] within CENT_MIN..CENT_MAX (default 19–20), year [15:8] 00–99, month [20:16] 01–12, weekday [23:21] 1–7, date [29:24] 01–31.
- R8: Status bit sources, each set on the edge that samples its source:
  - bit 0: `upd_ack_i`;
  - bit 1: alarm;
  - bit 2: `sec_ev_i`;
  - bit 3: `tim_ev_i`;
  - bit 4: `cal_ev_i`.
  Every bit stays set until a write to the clear command with a one in that bit position. Zero bits in the clear write leave their status bits unchanged.
- R9: If a status source and a clear command hit the same bit on the same edge, the bit ends up set.
- R10: Writing ones to the mask raise address sets the matching mask bits [4:0], and writing ones to the mask lower address clears them. Zero bits leave mask bits unchanged. The mask reads back at address 6.
- R11: `irq_o` is high exactly when the bitwise AND of status and mask is nonzero. It follows the registers with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 32 | Live BCD time word from the counter |
| cal_i | input | 32 | Live BCD calendar word from the counter |
| sec_ev_i | input | 1 | One-cycle second tick; also the alarm compare strobe |
| tim_ev_i | input | 1 | One-cycle time-field event pulse |
| cal_ev_i | input | 1 | One-cycle calendar-field event pulse |
| upd_ack_i | input | 1 | One-cycle update acknowledge pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from `reg_addr_i` |
| irq_o | output | 1 | Level interrupt request |

## Verification
A corrupted status or mask bit shows on `irq_o` in the same cycle it is wrong, and on the status or mask readback at the next read. A wrong field comparison, or a lost enable bit, shows as a missing or spurious alarm status bit one edge after the second tick that should or should not have matched. A faulty range rule is exposed at once on the validity readback. For that reason, every legal and illegal encoding of each alarm field, and of the live hour, weekday and century, is swept against arithmetic expectations. Every status pattern is crossed with every mask pattern.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned EVT_N  = 5;
  localparam int unsigned FLD_N  = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_TALM  = 3'd0,
    A_CALM  = 3'd1,
    A_STAT  = 3'd2,
    A_CLR   = 3'd3,
    A_IEN   = 3'd4,
    A_IDIS  = 3'd5,
    A_MASK  = 3'd6,
    A_VALID = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    CHK_TIME,
    CHK_CAL,
    CHK_CAL_ALARM
  } chk_kind_e;

  localparam int unsigned EV_UPD = 0;
  localparam int unsigned EV_ALM = 1;
  localparam int unsigned EV_SEC = 2;
  localparam int unsigned EV_TIM = 3;
  localparam int unsigned EV_CAL = 4;

  localparam logic [WORD_W-1:0] TALM_KEEP = 32'h00BF_FFFF;
  localparam logic [WORD_W-1:0] CALM_KEEP = 32'hBF9F_0000;
  localparam logic [WORD_W-1:0] CALM_RST  = 32'h0101_0000;

  // both nibbles decimal and value inside [lo, hi]
  function automatic logic bcd_ok(logic [7:0] v, logic [7:0] lo, logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/rtc_word_check.sv
module rtc_word_check
  import rtc_alarm_pkg::*;
#(
  parameter chk_kind_e  KIND     = CHK_TIME,
  parameter logic [7:0] CENT_MIN = 8'h19,
  parameter logic [7:0] CENT_MAX = 8'h20
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              valid_o
);
  logic unused_bits;
  assign unused_bits = ^word_i;

  logic [7:0] f_sec, f_min, f_hour, f_cent, f_year, f_month, f_day, f_date;
  assign f_sec   = {1'b0, word_i[6:0]};
  assign f_min   = {1'b0, word_i[14:8]};
  assign f_hour  = {2'b0, word_i[21:16]};
  assign f_cent  = {1'b0, word_i[6:0]};
  assign f_year  = word_i[15:8];
  assign f_month = {3'b0, word_i[20:16]};
  assign f_day   = {5'b0, word_i[23:21]};
  assign f_date  = {2'b0, word_i[29:24]};

  if (KIND == CHK_TIME) begin : g_time
    assign valid_o = bcd_ok(f_sec, 8'h00, 8'h59) && bcd_ok(f_min, 8'h00, 8'h59)
                  && bcd_ok(f_hour, 8'h00, 8'h23);
  end else if (KIND == CHK_CAL) begin : g_cal
    assign valid_o = bcd_ok(f_cent, CENT_MIN, CENT_MAX) && bcd_ok(f_year, 8'h00, 8'h99)
                  && bcd_ok(f_month, 8'h01, 8'h12) && bcd_ok(f_day, 8'h01, 8'h07)
                  && bcd_ok(f_date, 8'h01, 8'h31);
  end else begin : g_cal_alarm
    assign valid_o = bcd_ok(f_month, 8'h01, 8'h12) && bcd_ok(f_date, 8'h01, 8'h31);
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] time_i,
  input  logic [WORD_W-1:0] cal_i,
  input  logic [WORD_W-1:0] talm_i,
  input  logic [WORD_W-1:0] calm_i,
  input  logic              talm_ok_i,
  input  logic              calm_ok_i,
  output logic              hit_o
);
  // sec, min, hour from the time word; month, date from the calendar word
  localparam int F_LSB [FLD_N] = '{0, 8, 16, 16, 24};
  localparam int F_W   [FLD_N] = '{7, 7, 6, 5, 6};
  localparam int F_EN  [FLD_N] = '{7, 15, 23, 23, 31};
  localparam logic [FLD_N-1:0] F_CAL = 5'b11000;

  logic unused_bits;
  assign unused_bits = ^{time_i, cal_i, talm_i, calm_i};

  logic [FLD_N-1:0] en, eq;

  for (genvar i = 0; i < FLD_N; i++) begin : g_fld
    localparam int LSB = F_LSB[i];
    localparam int W   = F_W[i];
    localparam int ENB = F_EN[i];
    logic [W-1:0] cur, ref_v;
    if (F_CAL[i]) begin : g_c
      assign cur   = cal_i[LSB +: W];
      assign ref_v = calm_i[LSB +: W];
      assign en[i] = calm_i[ENB];
    end else begin : g_t
      assign cur   = time_i[LSB +: W];
      assign ref_v = talm_i[LSB +: W];
      assign en[i] = talm_i[ENB];
    end
    assign eq[i] = (cur == ref_v);
  end

  assign hit_o = tick_i && (|en) && talm_ok_i && calm_ok_i && (&(eq | ~en));

  assert_no_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (talm_i[23] == 1'b0 && talm_i[15] == 1'b0 && talm_i[7] == 1'b0
     && calm_i[31] == 1'b0 && calm_i[23] == 1'b0) |-> !hit_o);

  assert_invalid_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(talm_ok_i && calm_ok_i) |-> !hit_o);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned N = EVT_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         ien_we_i,
  input  logic         idis_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] status_q, mask_q, clr_vec;

  assign clr_vec = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_i;
      if (ien_we_i)       mask_q <= mask_q | wdata_i;
      else if (idis_we_i) mask_q <= mask_q & ~wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));

  assert_mask_raise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_we_i |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));

  assert_mask_lower_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idis_we_i |=> ((mask_o & $past(wdata_i)) == '0));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter logic [7:0] CENT_MIN = 8'h19,
  parameter logic [7:0] CENT_MAX = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] time_i,
  input  logic [WORD_W-1:0] cal_i,
  input  logic              sec_ev_i,
  input  logic              tim_ev_i,
  input  logic              cal_ev_i,
  input  logic              upd_ack_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] talm_q, calm_q;
  logic              time_ok, cal_ok, talm_ok, calm_ok, alarm_hit;
  logic [EVT_N-1:0]  ev_set, status, mask;
  reg_addr_e         addr;

  assign addr = reg_addr_e'(reg_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      talm_q <= '0;
      calm_q <= CALM_RST;
    end else if (reg_we_i) begin
      if (addr == A_TALM) talm_q <= reg_wdata_i & TALM_KEEP;
      if (addr == A_CALM) calm_q <= reg_wdata_i & CALM_KEEP;
    end
  end

  rtc_word_check #(.KIND(CHK_TIME), .CENT_MIN(CENT_MIN), .CENT_MAX(CENT_MAX)) i_chk_time (
    .word_i(time_i), .valid_o(time_ok));
  rtc_word_check #(.KIND(CHK_CAL), .CENT_MIN(CENT_MIN), .CENT_MAX(CENT_MAX)) i_chk_cal (
    .word_i(cal_i), .valid_o(cal_ok));
  rtc_word_check #(.KIND(CHK_TIME), .CENT_MIN(CENT_MIN), .CENT_MAX(CENT_MAX)) i_chk_talm (
    .word_i(talm_q), .valid_o(talm_ok));
  rtc_word_check #(.KIND(CHK_CAL_ALARM), .CENT_MIN(CENT_MIN), .CENT_MAX(CENT_MAX)) i_chk_calm (
    .word_i(calm_q), .valid_o(calm_ok));

  rtc_alarm_match i_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (sec_ev_i),
    .time_i    (time_i),
    .cal_i     (cal_i),
    .talm_i    (talm_q),
    .calm_i    (calm_q),
    .talm_ok_i (talm_ok),
    .calm_ok_i (calm_ok),
    .hit_o     (alarm_hit)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[EV_UPD] = upd_ack_i;
    ev_set[EV_ALM] = alarm_hit;
    ev_set[EV_SEC] = sec_ev_i;
    ev_set[EV_TIM] = tim_ev_i;
    ev_set[EV_CAL] = cal_ev_i;
  end

  rtc_irq_ctrl #(.N(EVT_N)) i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ev_set),
    .clr_we_i  (reg_we_i && addr == A_CLR),
    .ien_we_i  (reg_we_i && addr == A_IEN),
    .idis_we_i (reg_we_i && addr == A_IDIS),
    .wdata_i   (reg_wdata_i[EVT_N-1:0]),
    .status_o  (status),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      A_TALM:  reg_rdata_o = talm_q;
      A_CALM:  reg_rdata_o = calm_q;
      A_STAT:  reg_rdata_o[EVT_N-1:0] = status;
      A_MASK:  reg_rdata_o[EVT_N-1:0] = mask;
      A_VALID: reg_rdata_o[3:0] = {~calm_ok, ~talm_ok, ~cal_ok, ~time_ok};
      default: reg_rdata_o = '0;
    endcase
  end

  assert_alarm_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && addr == A_TALM) |=> (talm_q == ($past(reg_wdata_i) & TALM_KEEP)));
endmodule

// File: tb/test_rtc_alarm_irq.sv
`timescale 1ns/1ps
module test_rtc_alarm_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] time_w, cal_w, wdata, rdata;
  logic        sec_ev = 0, tim_ev = 0, cal_ev = 0, upd_ack = 0, we = 0, irq;
  logic [2:0]  addr = 3'd0;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_irq i_rtc_alarm_irq (
    .clk_i(clk), .rst_ni(rst_n), .time_i(time_w), .cal_i(cal_w),
    .sec_ev_i(sec_ev), .tim_ev_i(tim_ev), .cal_ev_i(cal_ev), .upd_ack_i(upd_ack),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  function automatic logic [31:0] mk_cal(input logic [7:0] cent, year, month, day, date);
    return {2'b0, date[5:0], day[2:0], month[4:0], year, 1'b0, cent[6:0]};
  endfunction

  // decimal legality computed arithmetically
  function automatic bit dec_ok(input int v, input int lo, input int hi);
    int n;
    n = (v / 16) * 10 + (v % 16);
    return ((v % 16) <= 9) && ((v / 16) <= 9) && n >= lo && n <= hi;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [3:0] p); // {cal,tim,sec,upd}
    @(negedge clk); {cal_ev, tim_ev, sec_ev, upd_ack} = p;
    @(negedge clk); {cal_ev, tim_ev, sec_ev, upd_ack} = 4'b0;
  endtask

  task automatic alarm_bit(input string req, input logic exp);
    logic [31:0] d;
    wr(3'd3, 32'h1F);
    pulse(4'b0010);
    rd(3'd2, d);
    chk(req, {31'b0, d[1]}, {31'b0, exp});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    time_w = 32'h0012_0000;
    cal_w  = mk_cal(8'h20, 8'h24, 8'h04, 8'h03, 8'h27);
    wdata  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(3'd0, d); chk("R1 talm", d, 32'h0);
    rd(3'd1, d); chk("R1 calm", d, 32'h0101_0000);
    rd(3'd2, d); chk("R1 status", d, 32'h0);
    rd(3'd6, d); chk("R1 mask", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(3'd7, d); chk("R1 valid", d, 32'h0);

    // R3 / R4 readback keeps only defined bits
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); chk("R3 keep", d, 32'h00BF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); chk("R4 keep", d, 32'hBF9F_0000);
    wr(3'd1, 32'h0101_0000);

    // R6 sweeps of alarm fields
    for (int v = 0; v < 128; v++) begin
      wr(3'd0, v); rd(3'd7, d);
      chk("R6 talm sec", {31'b0, d[2]}, {31'b0, !dec_ok(v, 0, 59)});
      wr(3'd0, v << 8); rd(3'd7, d);
      chk("R6 talm min", {31'b0, d[2]}, {31'b0, !dec_ok(v, 0, 59)});
    end
    for (int v = 0; v < 64; v++) begin
      wr(3'd0, v << 16); rd(3'd7, d);
      chk("R6 talm hour", {31'b0, d[2]}, {31'b0, !dec_ok(v, 0, 23)});
      wr(3'd1, (v << 24) | 32'h0001_0000); rd(3'd7, d);
      chk("R6 calm date", {31'b0, d[3]}, {31'b0, !dec_ok(v, 1, 31)});
    end
    for (int v = 0; v < 32; v++) begin
      wr(3'd1, (v << 16) | 32'h0100_0000); rd(3'd7, d);
      chk("R6 calm month", {31'b0, d[3]}, {31'b0, !dec_ok(v, 1, 12)});
    end
    wr(3'd0, 32'h0); wr(3'd1, 32'h0101_0000);

    // R7 live word sweeps
    for (int v = 0; v < 64; v++) begin
      time_w = v << 16; rd(3'd7, d);
      chk("R7 time hour", {31'b0, d[0]}, {31'b0, !dec_ok(v, 0, 23)});
    end
    time_w = 32'h0012_0000;
    for (int v = 0; v < 8; v++) begin
      cal_w = mk_cal(8'h20, 8'h24, 8'h04, v[7:0], 8'h27); rd(3'd7, d);
      chk("R7 weekday", {31'b0, d[1]}, {31'b0, !dec_ok(v, 1, 7)});
    end
    for (int v = 0; v < 128; v++) begin
      cal_w = mk_cal(v[7:0], 8'h24, 8'h04, 8'h03, 8'h27); rd(3'd7, d);
      chk("R7 century", {31'b0, d[1]}, {31'b0, !dec_ok(v, 19, 20)});
    end
    cal_w = mk_cal(8'h20, 8'h24, 8'h04, 8'h03, 8'h27);

    // R5 alarm matching
    time_w = 32'h0012_0030;
    wr(3'd0, 32'h0000_0030);
    alarm_bit("R5 no enable", 1'b0);
    rd(3'd2, d); chk("R8 sec event sticky", {31'b0, d[2]}, 32'h1);
    wr(3'd0, 32'h0000_00B0);
    alarm_bit("R5 sec match", 1'b1);
    wr(3'd3, 32'h02); rd(3'd2, d);
    chk("R8 w1c alarm only", d, 32'h04);
    time_w = 32'h0012_0031;
    alarm_bit("R5 sec mismatch", 1'b0);
    wr(3'd0, 32'h0092_0000); time_w = 32'h0012_5931;
    alarm_bit("R5 hour only", 1'b1);
    time_w = 32'h0013_5931;
    alarm_bit("R5 hour mismatch", 1'b0);
    wr(3'd0, 32'h0); wr(3'd1, 32'hA784_0000);
    cal_w = mk_cal(8'h19, 8'h99, 8'h04, 8'h05, 8'h27);
    alarm_bit("R4 date month, year ignored", 1'b1);
    cal_w = mk_cal(8'h19, 8'h99, 8'h04, 8'h05, 8'h28);
    alarm_bit("R4 date mismatch", 1'b0);
    wr(3'd1, 32'h0101_0000);

    // R6 illegal alarm suppresses matching until rewritten
    wr(3'd0, 32'h0000_00DA); time_w = 32'h0012_005A;
    alarm_bit("R6 illegal suppress", 1'b0);
    rd(3'd7, d); chk("R6 valid flag", {31'b0, d[2]}, 32'h1);
    wr(3'd0, 32'h0000_00B0); time_w = 32'h0012_0030;
    alarm_bit("R6 rewrite restores", 1'b1);

    // R8 / R9 clear and set priority
    wr(3'd3, 32'h1F); pulse(4'b1000); pulse(4'b0001);
    wr(3'd3, 32'h10); rd(3'd2, d); chk("R8 w1c cal", d, 32'h01);
    @(negedge clk); sec_ev = 1; we = 1; addr = 3'd3; wdata = 32'h04;
    time_w = 32'h0012_0031;
    @(negedge clk); sec_ev = 0; we = 0;
    rd(3'd2, d); chk("R9 set beats clear", d, 32'h05);

    // R2 address rules
    rd(3'd3, d); chk("R2 wo read zero", d, 32'h0);
    wr(3'd2, 32'h0); rd(3'd2, d); chk("R2 ro write ignored", d, 32'h05);

    // R10 / R11 every status pattern crossed with every mask pattern
    wr(3'd0, 32'h0000_00B0);
    for (int s = 0; s < 32; s++) begin
      wr(3'd3, 32'h1F);
      if (s[1]) begin
        time_w = 32'h0012_0030; pulse(4'b0010); wr(3'd3, 32'h04);
      end
      time_w = 32'h0012_0031;
      pulse({s[4], s[3], s[2], s[0]});
      rd(3'd2, d); chk("R8 status pattern", d, s);
      for (int m = 0; m < 32; m++) begin
        wr(3'd5, 32'h1F); wr(3'd4, m);
        rd(3'd6, d); chk("R10 mask", d, m);
        chk("R11 irq", {31'b0, irq}, {31'b0, (s & m) != 0});
      end
    end
    wr(3'd5, 32'h0A); rd(3'd6, d); chk("R10 lower", d, 32'h15);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule